// File: doc/BRIEF.md
# Atomic Reservation Unit for Load-Linked / Store-Conditional

This unit sits between the execute stage of a 32-bit core and a simple synchronous data memory port. It carries out the atomic word pair: a load-atomic and a store-atomic. A load-atomic reads one word and returns it to the core. It also records the effective address and the word it read as a reservation. A later store-atomic succeeds only if two things hold. Its effective address must equal the reserved address. A fresh read of memory at that address must also return the word recorded at load time. On success the store-atomic writes its source word, and it reports the outcome through the core's condition flag.

The reservation is dropped after every store-atomic, whatever the outcome. It is also dropped at reset, on exception entry, on return from exception and on an address-translation fault. An all-ones reserved address means that no reservation is held. While the unit owns the memory port it raises `busy`, and the core must hold off. The check-then-write sequence therefore cannot be split by another access from the same core.

Top module: `llsc_resv_unit`

## Requirements
- R1: An instruction is decoded only when `ex_valid` is high and `busy` is low. A value of 0x1B in `ex_insn[31:26]` selects the load-atomic and 0x33 selects the store-atomic. Any other opcode is ignored: `mem_req` stays low and `busy` stays low.
- R2: The load-atomic effective address is `ex_base` plus the sign-extended `ex_insn[15:0]`. The store-atomic effective address is `ex_base` plus the sign-extended 16-bit value {`ex_insn[25:21]`, `ex_insn[10:0]`}.
- R3: A load-atomic issues a read at its effective address in the cycle it is accepted. Two cycles later it pulses `ld_done` with the word read on `ld_data`, and it records that address and word as the reservation.
- R4: A store-atomic whose effective address differs from the reserved address fails. It makes no memory access and pulses `flag_we` with `flag_val`=0 one cycle after acceptance.
- R5: A store-atomic whose address matches reads the reserved address in the acceptance cycle. If the word equals the reserved word, it writes `ex_src` there in the next cycle, straight after the read, and pulses `flag_we` with `flag_val`=1 two cycles after acceptance.
- R6: If the re-read word differs from the reserved word, nothing is written and `flag_we` pulses with `flag_val`=0 two cycles after acceptance.
- R7: Every store-atomic drops the reservation, so a second store-atomic to the same address without a new load-atomic fails.
- R8: The reservation is dropped by reset, `exc_enter`, `exc_return` and `mmu_fault`. A drop request wins over a load-atomic capture in the same cycle.
- R9: An all-ones reserved address means no reservation, so a store-atomic to 0xFFFFFFFF with no load-atomic before it fails.
- R10: `busy` is high from the cycle after acceptance through the result cycle, and an instruction offered while `busy` is high is ignored.
- R11: `ld_done` and `flag_we` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | Execute stage offers an instruction |
| ex_insn | input | 32 | Instruction word |
| ex_base | input | 32 | Base register value |
| ex_src | input | 32 | Store source register value |
| busy | output | 1 | Stall request to the pipeline |
| ld_done | output | 1 | Load-atomic result valid |
| ld_data | output | 32 | Loaded word |
| flag_we | output | 1 | Condition flag update strobe |
| flag_val | output | 1 | Store-atomic outcome (1 = success) |
| exc_enter | input | 1 | Exception entry, drops reservation |
| exc_return | input | 1 | Return from exception, drops reservation |
| mmu_fault | input | 1 | Translation fault, drops reservation |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
Each result has a fixed delay from the cycle an instruction is accepted. A load-atomic result comes two cycles later. A store-atomic that misses on address reports one cycle later. One that reaches the re-read reports two cycles later, and any write lands one cycle after acceptance. The bench model turns each instruction into an expected event stamped with that due cycle. On every falling edge it compares `ld_done`, `flag_we` and their data against the event due in that cycle, and expects both strobes low in every other cycle. Memory contents are compared with a shadow copy after each store-atomic. This catches both stray results and results that arrive one cycle early or late.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    localparam int XLEN  = 32;
    localparam int OPC_W = 6;
    localparam int IMM_W = 16;
    localparam int OPC_LSB = XLEN - OPC_W;

    localparam logic [OPC_W-1:0] OPC_LOAD_ATOMIC  = 6'h1B;
    localparam logic [OPC_W-1:0] OPC_STORE_ATOMIC = 6'h33;

    localparam logic [XLEN-1:0] NO_RESV = '1;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOAD,
        OP_STORE
    } atom_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LD_RD,
        SQ_ST_RD,
        SQ_LD_FIN,
        SQ_ST_FIN
    } seq_state_e;

    typedef struct packed {
        atom_op_e        op;
        logic [XLEN-1:0] ea;
        logic [XLEN-1:0] wdata;
    } atom_req_t;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] value;
    } resv_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction
endpackage

// File: rtl/llsc_decode.sv
module llsc_decode
    import llsc_pkg::*;
(
    input  logic            ex_valid,
    input  logic            accept_en,
    input  logic [XLEN-1:0] insn,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] src,
    output atom_req_t       req
);
    logic [IMM_W-1:0] imm_ld;
    logic [IMM_W-1:0] imm_st;
    logic             unused_fields;

    assign imm_ld        = insn[IMM_W-1:0];
    assign imm_st        = {insn[25:21], insn[10:0]};
    assign unused_fields = ^insn[20:16];

    always_comb begin
        req.op    = OP_NONE;
        req.ea    = base + sext_imm(imm_ld);
        req.wdata = src;
        if (ex_valid && accept_en) begin
            case (insn[XLEN-1:OPC_LSB])
                OPC_LOAD_ATOMIC: begin
                    req.op = OP_LOAD;
                end
                OPC_STORE_ATOMIC: begin
                    req.op = OP_STORE;
                    req.ea = base + sext_imm(imm_st);
                end
                default: req.op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg
    import llsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            cap,
    input  logic [XLEN-1:0] cap_addr,
    input  logic [XLEN-1:0] cap_value,
    input  logic            inv,
    output resv_t           resv
);
    always_ff @(posedge clk) begin
        if (rst) begin
            resv.addr  <= NO_RESV;
            resv.value <= '0;
        end else begin
            if (cap) begin
                resv.value <= cap_value;
            end
            if (clr || inv) begin
                resv.addr <= NO_RESV;
            end else if (cap) begin
                resv.addr <= cap_addr;
            end
        end
    end
endmodule

// File: rtl/llsc_seq.sv
module llsc_seq
    import llsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  atom_req_t       req,
    input  resv_t           resv,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            busy,
    output logic            ld_done,
    output logic [XLEN-1:0] ld_data,
    output logic            flag_we,
    output logic            flag_val,
    output logic            cap,
    output logic [XLEN-1:0] cap_addr,
    output logic [XLEN-1:0] cap_value,
    output logic            inv
);
    seq_state_e      state_q, state_d;
    logic [XLEN-1:0] addr_q, addr_d;
    logic [XLEN-1:0] wdat_q, wdat_d;
    logic [XLEN-1:0] ld_q, ld_d;
    logic            res_q, res_d;
    logic            hit;

    assign hit = (resv.addr != NO_RESV) && (req.ea == resv.addr);

    always_comb begin
        state_d   = state_q;
        addr_d    = addr_q;
        wdat_d    = wdat_q;
        ld_d      = ld_q;
        res_d     = res_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req.ea;
        mem_wdata = wdat_q;
        cap       = 1'b0;
        cap_addr  = addr_q;
        cap_value = mem_rdata;
        inv       = 1'b0;
        case (state_q)
            SQ_IDLE: begin
                if (req.op == OP_LOAD) begin
                    mem_req = 1'b1;
                    addr_d  = req.ea;
                    state_d = SQ_LD_RD;
                end else if (req.op == OP_STORE) begin
                    addr_d = req.ea;
                    wdat_d = req.wdata;
                    if (hit) begin
                        mem_req = 1'b1;
                        state_d = SQ_ST_RD;
                    end else begin
                        inv     = 1'b1;
                        res_d   = 1'b0;
                        state_d = SQ_ST_FIN;
                    end
                end
            end
            SQ_LD_RD: begin
                cap     = 1'b1;
                ld_d    = mem_rdata;
                state_d = SQ_LD_FIN;
            end
            SQ_ST_RD: begin
                inv      = 1'b1;
                mem_addr = addr_q;
                if (mem_rdata == resv.value) begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                    res_d   = 1'b1;
                end else begin
                    res_d   = 1'b0;
                end
                state_d = SQ_ST_FIN;
            end
            SQ_LD_FIN: state_d = SQ_IDLE;
            SQ_ST_FIN: state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
            wdat_q  <= '0;
            ld_q    <= '0;
            res_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            wdat_q  <= wdat_d;
            ld_q    <= ld_d;
            res_q   <= res_d;
        end
    end

    assign busy     = (state_q != SQ_IDLE);
    assign ld_done  = (state_q == SQ_LD_FIN);
    assign ld_data  = ld_q;
    assign flag_we  = (state_q == SQ_ST_FIN);
    assign flag_val = res_q;
endmodule

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit
    import llsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ex_valid,
    input  logic [XLEN-1:0] ex_insn,
    input  logic [XLEN-1:0] ex_base,
    input  logic [XLEN-1:0] ex_src,
    output logic            busy,
    output logic            ld_done,
    output logic [XLEN-1:0] ld_data,
    output logic            flag_we,
    output logic            flag_val,
    input  logic            exc_enter,
    input  logic            exc_return,
    input  logic            mmu_fault,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata
);
    atom_req_t       req;
    resv_t           resv;
    logic            cap;
    logic            inv;
    logic [XLEN-1:0] cap_addr;
    logic [XLEN-1:0] cap_value;
    logic            clr;
    logic [XLEN-1:0] lock_addr;

    assign clr       = exc_enter | exc_return | mmu_fault;
    assign lock_addr = resv.addr;

    llsc_decode u_dec (
        .ex_valid  (ex_valid),
        .accept_en (!busy),
        .insn      (ex_insn),
        .base      (ex_base),
        .src       (ex_src),
        .req       (req)
    );

    llsc_resv_reg u_resv (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .cap       (cap),
        .cap_addr  (cap_addr),
        .cap_value (cap_value),
        .inv       (inv),
        .resv      (resv)
    );

    llsc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .resv      (resv),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .ld_done   (ld_done),
        .ld_data   (ld_data),
        .flag_we   (flag_we),
        .flag_val  (flag_val),
        .cap       (cap),
        .cap_addr  (cap_addr),
        .cap_value (cap_value),
        .inv       (inv)
    );
endmodule

// File: rtl/llsc_resv_chk.sv
module llsc_resv_chk
    import llsc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            mem_req,
    input logic            mem_we,
    input logic            busy,
    input logic            ld_done,
    input logic            flag_we,
    input logic            flag_val,
    input logic            clr_any,
    input logic [XLEN-1:0] lock_addr
);
    a_r5_write_follows_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we));

    a_r5_write_gives_success: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> (flag_we && flag_val));

    a_r6_success_needs_write: assert property (@(posedge clk) disable iff (rst)
        (flag_we && flag_val) |-> $past(mem_req && mem_we));

    a_r8_clear_drops_lock: assert property (@(posedge clk) disable iff (rst)
        clr_any |=> (lock_addr == NO_RESV));

    a_r10_result_while_busy: assert property (@(posedge clk) disable iff (rst)
        (ld_done || flag_we) |-> busy);

    a_r11_single_result: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_done, flag_we}));

    a_r11_pulse_ld: assert property (@(posedge clk) disable iff (rst)
        ld_done |=> !ld_done);
endmodule

bind llsc_resv_unit llsc_resv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .busy      (busy),
    .ld_done   (ld_done),
    .flag_we   (flag_we),
    .flag_val  (flag_val),
    .clr_any   (exc_enter | exc_return | mmu_fault),
    .lock_addr (lock_addr)
);

// File: tb/llsc_resv_unit_tb_top.sv
module llsc_resv_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ex_valid = 1'b0;
    logic [31:0] ex_insn = '0;
    logic [31:0] ex_base = '0;
    logic [31:0] ex_src = '0;
    logic        busy, ld_done, flag_we, flag_val;
    logic [31:0] ld_data;
    logic        exc_enter = 1'b0, exc_return = 1'b0, mmu_fault = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    llsc_resv_unit dut_i (
        .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_insn(ex_insn),
        .ex_base(ex_base), .ex_src(ex_src), .busy(busy), .ld_done(ld_done),
        .ld_data(ld_data), .flag_we(flag_we), .flag_val(flag_val),
        .exc_enter(exc_enter), .exc_return(exc_return), .mmu_fault(mmu_fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct { int due; bit is_ld; logic [31:0] val; } exp_t;
    exp_t exp_q[$];

    logic [31:0] dmem [64];
    logic [31:0] smem [64];
    logic        poke_en = 1'b0;
    logic [5:0]  poke_idx = '0;
    logic [31:0] poke_val = '0;
    logic [31:0] lock_a = 32'hFFFF_FFFF;
    logic [31:0] lock_v = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            for (int i = 0; i < 64; i++) dmem[i] <= 32'h1000 + i * 32'h0101_0101;
        end else begin
            if (mem_req && mem_we) dmem[mem_addr[7:2]] <= mem_wdata;
            else if (mem_req) mem_rdata <= dmem[mem_addr[7:2]];
            if (poke_en) dmem[poke_idx] <= poke_val;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model's expected events (R3 R4 R5 R6 R11)
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_ld, e_fl;
            logic [31:0] e_val;
            e_ld = 0; e_fl = 0; e_val = '0;
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                e_ld = exp_q[0].is_ld;
                e_fl = !exp_q[0].is_ld;
                e_val = exp_q[0].val;
                void'(exp_q.pop_front());
            end
            check(ld_done == e_ld, "R3/R11 ld_done", {31'd0, ld_done}, {31'd0, e_ld});
            check(flag_we == e_fl, "R4/R11 flag_we", {31'd0, flag_we}, {31'd0, e_fl});
            if (e_ld && ld_done) check(ld_data == e_val, "R3 ld_data", ld_data, e_val);
            if (e_fl && flag_we) check(flag_val == e_val[0], "R5/R6 flag_val", {31'd0, flag_val}, e_val);
        end
    end

    always @(negedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic poke(input logic [31:0] addr, input logic [31:0] val);
        poke_en = 1; poke_idx = addr[7:2]; poke_val = val;
        @(negedge clk);
        poke_en = 0;
        smem[addr[7:2]] = val;
    endtask

    task automatic do_load(input logic [31:0] base, input logic [15:0] imm);
        logic [31:0] ea;
        exp_t e;
        ea = base + sx(imm);
        e.due = cyc + 2; e.is_ld = 1; e.val = smem[ea[7:2]];
        exp_q.push_back(e);
        lock_a = ea; lock_v = smem[ea[7:2]];
        ex_valid = 1; ex_insn = {6'h1B, 10'd0, imm}; ex_base = base;
        wait_idle();
        ex_valid = 0;
        @(negedge clk);
    endtask

    task automatic do_store(input logic [31:0] base, input logic [15:0] imm,
                            input logic [31:0] src, input bit hold, input string tag);
        logic [31:0] ea;
        bit hit, ok;
        exp_t e;
        ea = base + sx(imm);
        hit = (lock_a != 32'hFFFF_FFFF) && (ea == lock_a);
        ok = hit && (smem[ea[7:2]] == lock_v);
        e.due = hit ? cyc + 2 : cyc + 1; e.is_ld = 0; e.val = {31'd0, ok};
        exp_q.push_back(e);
        if (ok) smem[ea[7:2]] = src;
        lock_a = 32'hFFFF_FFFF;
        ex_valid = 1; ex_insn = {6'h33, imm[15:11], 10'd0, imm[10:0]};
        ex_base = base; ex_src = src;
        @(negedge clk);
        if (!hold) ex_valid = 0;
        else begin
            // R10: same store offered again while busy, must be ignored
            check(busy == 1'b1, "R10 busy during sequence", {31'd0, busy}, 32'd1);
            @(negedge clk);
            ex_valid = 0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        check(dmem[ea[7:2]] == smem[ea[7:2]], tag, dmem[ea[7:2]], smem[ea[7:2]]);
    endtask

    task automatic pulse_clear(input int which);
        if (which == 0) exc_enter = 1;
        else if (which == 1) exc_return = 1;
        else mmu_fault = 1;
        @(negedge clk);
        exc_enter = 0; exc_return = 0; mmu_fault = 0;
        lock_a = 32'hFFFF_FFFF;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) smem[i] = 32'h1000 + i * 32'h0101_0101;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !ld_done && !flag_we && !mem_req, "reset state",
              {28'd0, busy, ld_done, flag_we, mem_req}, 32'd0);

        // R8/R9: no reservation after reset
        do_store(32'h10, 16'h0000, 32'hAAAA_0001, 0, "R8 store after reset no write");
        // R2/R3/R5: load with positive offset, store with negative split offset
        do_load(32'h10, 16'h0010);
        do_store(32'h30, 16'hFFF0, 32'hCAFE_F00D, 0, "R5 successful write");
        // R7: second store to same address fails
        do_store(32'h20, 16'h0000, 32'h1111_2222, 0, "R7 no write after store");
        // R4 then R7: address mismatch, then even the right address fails
        do_load(32'h40, 16'h0000);
        do_store(32'h44, 16'h0000, 32'h3333_4444, 0, "R4 mismatch no write");
        do_store(32'h40, 16'h0000, 32'h5555_6666, 0, "R7 invalidated by failed store");
        // R6: value changed between load and store
        do_load(32'h40, 16'h0000);
        poke(32'h40, 32'hDEAD_BEEF);
        do_store(32'h40, 16'h0000, 32'h7777_8888, 0, "R6 value mismatch no write");
        // R8: each clear source
        for (int k = 0; k < 3; k++) begin
            do_load(32'h50, 16'h0004);
            pulse_clear(k);
            do_store(32'h54, 16'h0000, 32'h9999_0000 + k, 0, "R8 cleared reservation");
        end
        // R9: all-ones effective address with no reservation
        do_store(32'hFFFF_FFFF, 16'h0000, 32'hABCD_0000, 0, "R9 all-ones address fails");
        // R1: non-atomic opcode ignored
        ex_valid = 1; ex_insn = {6'h21, 26'd0}; ex_base = 32'h60;
        #1;
        check(mem_req == 1'b0, "R1 other opcode no access", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
        check(busy == 1'b0, "R1 other opcode no busy", {31'd0, busy}, 32'd0);
        ex_valid = 0;
        @(negedge clk);
        // R10: held store during busy, single result, then success
        do_load(32'h60, 16'h0008);
        do_store(32'h68, 16'h0000, 32'h0BAD_C0DE, 1, "R10 held store single write");
        // R2/R3: load with negative offset, then reload replaces reservation
        do_load(32'h80, 16'hFFFC);
        do_load(32'h90, 16'h0000);
        do_store(32'h7C, 16'h0000, 32'h1212_3434, 0, "R3 old reservation replaced");
        do_load(32'h90, 16'h0000);
        do_store(32'h90, 16'h0000, 32'h5656_7878, 0, "R5 success after reload");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R11 all expected results seen", exp_q.size(), 32'd0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule